// File: doc/BRIEF.md
# DMA Descriptor Channel Controller

This block is the control logic of a single DMA channel that can chain buffer descriptors. Software, or a descriptor fetched from memory, writes a 32-bit control word. Bit 0 is the run enable and bit 1 is the chain (load-next) flag, and together they select one of four commands:

| Bit 0 | Bit 1 | Command |
|---|---|---|
| 0 | 0 | halt at once |
| 1 | 0 | run, then stop when the buffer is finished |
| 0 | 1 | fetch the next descriptor now |
| 1 | 1 | run, then fetch the next descriptor when the buffer is finished |

The channel keeps two status flags: a running flag (`st_en`) and an active flag (`st_act`). It moves one data beat per cycle into a small staging FIFO while a transfer request is present. When it is halted mid-buffer, it empties that FIFO before it drops its running flag. It asks a descriptor port for the next descriptor whenever the chaining rules call for one.

The control word layout is as follows:

| Bits | Field |
|---|---|
| 0 | run enable |
| 1 | chain |
| 2 | end-of-transfer enable (stored only) |
| 3 | end-of-buffer enable (stored only) |
| 4 | end-of-transfer interrupt enable (stored only) |
| 5 | buffer-end interrupt enable |
| 6 | descriptor-loaded interrupt enable |
| 7 | burst lock (stored only) |
| 31:16 | remaining beat count |

The remaining beat count counts down in place as beats enter the FIFO. The buffer address comes only from descriptor loads, and it advances by `STEP` for each beat that enters the FIFO. The data-mover side sees `out_valid` while the FIFO holds a beat and removes one beat on every cycle in which `out_rdy` is also high.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset, `st_en`, `st_act`, `out_valid`, `desc_req` and both interrupt outputs are 0, and `ctl_word` and `buf_addr` are 0.
- R2: While `st_en` is 0 or bit 0 of `ctl_word` is 0, a transfer request moves no beat: `out_valid` stays 0 from an empty FIFO and bits 31:16 of `ctl_word` do not change.
- R3: The cycle after a write with bit 0 set, `st_en` is 1. While a request is present, the remaining count is nonzero and the FIFO holds fewer than `DEPTH` beats, one beat per cycle enters the FIFO. Each entering beat decrements bits 31:16 by one and advances `buf_addr` by `STEP`. The FIFO never holds more than `DEPTH` beats, and every buffer delivers exactly its count of beats to the data mover.
- R4: With bit 0 set, once the remaining count is 0 and the FIFO is empty, `st_en` clears on the next edge. `irq_buf_end` then pulses for one cycle if bit 5 is set.
- R5: A write with bit 0 clear while beats remain in the FIFO stops new beats from entering. `st_en` stays 1 until the FIFO has emptied, and then clears.
- R6: With bits 0 and 1 both set, `desc_req` rises in the same cycle in which `st_en` falls at the end of the buffer.
- R7: With `st_en` 0, bit 0 clear and bit 1 set, `desc_req` stays 0 until a transfer request is sampled, and it is 1 in the following cycle. No beat moves.
- R8: A write with bit 0 clear and bit 1 set while `st_en` is 1 skips the rest of the current descriptor. No further beat enters the FIFO, the remaining count stays unchanged, and `desc_req` rises as soon as `st_en` has cleared.
- R9: `desc_req` holds until `desc_ack`. On the edge where both are high, `ctl_word` and `buf_addr` take the descriptor port values, `st_en` takes bit 0 of the new word, and `desc_req` drops. `irq_desc_loaded` pulses for exactly one cycle if bit 6 of the new word is set.
- R10: `st_act` is 1 exactly while the FIFO holds a beat. A loaded descriptor with bits 0 and 1 clear leaves the channel idle, with no request and no movement, until software writes bit 0 set again.
- R11: With bit 0 set and bit 1 clear, the end of the buffer raises no descriptor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Software write strobe for the control word |
| ctl_wdata | input | 32 | Control word written by software |
| ctl_word | output | 32 | Current control word, including the live remaining count |
| buf_addr | output | AW | Current buffer address |
| xfer_req | input | 1 | Transfer request from the endpoint side |
| out_valid | output | 1 | FIFO holds a beat for the data mover |
| out_rdy | input | 1 | Data mover takes a beat |
| desc_req | output | 1 | Request for the next descriptor |
| desc_ack | input | 1 | Descriptor port delivers a descriptor |
| desc_ctl_in | input | 32 | Control word of the delivered descriptor |
| desc_addr_in | input | AW | Buffer address of the delivered descriptor |
| st_en | output | 1 | Channel running flag |
| st_act | output | 1 | Channel active flag (FIFO not empty) |
| irq_buf_end | output | 1 | Buffer-end pulse, gated by bit 5 |
| irq_desc_loaded | output | 1 | Descriptor-loaded pulse, gated by bit 6 |

## Verification
The bench goes after four corner cases.

- **Halt with a full FIFO.** The FIFO is filled with the data mover stalled, and then the channel is halted. A design that dropped `st_en` at once would strand four beats. A design that kept filling would change the remaining count.
- **Skip during a drain.** A skip is issued while the FIFO is still full. A controller that requested a descriptor before the drain, or that let the old buffer keep moving, shows up as an early `desc_req` or as a shrinking count.
- **Fetch-now with requests held low.** A design that fetched without waiting for a request raises `desc_req` too early.
- **Chaining modes.** Both chaining modes are run back to back across several descriptors. Random request and ready patterns then confirm the beat counts, the final addresses and a single buffer-end pulse per buffer, which catches off-by-one faults in the end-of-buffer test.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_word,
  output logic [AW-1:0] buf_addr,
  input  logic          xfer_req,
  output logic          out_valid,
  input  logic          out_rdy,
  output logic          desc_req,
  input  logic          desc_ack,
  input  logic [31:0]   desc_ctl_in,
  input  logic [AW-1:0] desc_addr_in,
  output logic          st_en,
  output logic          st_act,
  output logic          irq_buf_end,
  output logic          irq_desc_loaded
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic          drain, fetch_pend, eob_q, dl_q;

  wire [15:0] len  = ctl_word[31:16];
  wire        fill = st_en & ctl_word[0] & ~drain & xfer_req &
                     (len != 16'd0) & (cnt != CW'(DEPTH));
  wire        pop  = out_valid & out_rdy;
  wire        load = desc_req & desc_ack;

  assign out_valid       = (cnt != '0);
  assign st_act          = out_valid;
  assign desc_req        = fetch_pend & ~st_en;
  assign irq_buf_end     = eob_q;
  assign irq_desc_loaded = dl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_word   <= '0;
      buf_addr   <= '0;
      cnt        <= '0;
      st_en      <= 1'b0;
      drain      <= 1'b0;
      fetch_pend <= 1'b0;
      eob_q      <= 1'b0;
      dl_q       <= 1'b0;
    end else begin
      cnt   <= cnt + CW'(fill) - CW'(pop);
      eob_q <= 1'b0;
      dl_q  <= 1'b0;
      if (fill) buf_addr <= buf_addr + AW'(STEP);

      if (load) begin
        ctl_word   <= desc_ctl_in;
        buf_addr   <= desc_addr_in;
        st_en      <= desc_ctl_in[0];
        drain      <= 1'b0;
        fetch_pend <= 1'b0;
        dl_q       <= desc_ctl_in[6];
      end else if (ctl_wr) begin
        ctl_word <= ctl_wdata;
        if (ctl_wdata[0]) begin
          st_en <= 1'b1;
          drain <= 1'b0;
        end else if (st_en) begin
          if (out_valid | fill) drain <= 1'b1;
          else                  st_en <= 1'b0;
          if (ctl_wdata[1]) fetch_pend <= 1'b1;
        end
      end else begin
        if (fill) ctl_word[31:16] <= len - 16'd1;
        if (drain & ~out_valid) begin
          st_en <= 1'b0;
          drain <= 1'b0;
        end else if (st_en & ctl_word[0] & (len == 16'd0) & ~out_valid) begin
          st_en <= 1'b0;
          eob_q <= ctl_word[5];
          if (ctl_word[1]) fetch_pend <= 1'b1;
        end
        if (~st_en & ~ctl_word[0] & ctl_word[1] & xfer_req) fetch_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_desc_chan_chk.sv
module dma_desc_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [31:0] ctl_word,
  input logic        st_en,
  input logic        out_valid,
  input logic        desc_req,
  input logic        desc_ack,
  input logic [31:0] desc_ctl_in,
  input logic        irq_desc_loaded
);

  p_off_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_en && !ctl_wr && !(desc_req && desc_ack)) |=> $stable(ctl_word[31:16]));

  p_eob_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && ctl_word[0] && ctl_word[31:16] == 16'd0 && !out_valid && !ctl_wr) |=> !st_en);

  p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !ctl_word[0] && out_valid && !ctl_wr) |=> st_en);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_ack && !ctl_wr) |=> desc_req);

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && desc_ack) |=>
      (ctl_word == $past(desc_ctl_in) && st_en == $past(desc_ctl_in[0]) && !desc_req));

  p_dl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_desc_loaded |=> !irq_desc_loaded);

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_en && !ctl_wr && !(desc_req && desc_ack)) |=> !st_en);

endmodule

bind dma_desc_chan dma_desc_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
  .st_en(st_en), .out_valid(out_valid), .desc_req(desc_req),
  .desc_ack(desc_ack), .desc_ctl_in(desc_ctl_in),
  .irq_desc_loaded(irq_desc_loaded)
);

// File: tb/dma_desc_chan_tb.sv
module dma_desc_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_word;
  logic [31:0] buf_addr;
  logic        xfer_req = 1'b0;
  logic        out_valid;
  logic        out_rdy = 1'b0;
  logic        desc_req;
  logic        desc_ack = 1'b0;
  logic [31:0] desc_ctl_in = '0;
  logic [31:0] desc_addr_in = '0;
  logic        st_en, st_act, irq_buf_end, irq_desc_loaded;

  int checks = 0, fails = 0;
  int pops = 0, eobs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_chan #(.DEPTH(DEPTH), .AW(32), .STEP(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_word(ctl_word), .buf_addr(buf_addr), .xfer_req(xfer_req),
    .out_valid(out_valid), .out_rdy(out_rdy), .desc_req(desc_req),
    .desc_ack(desc_ack), .desc_ctl_in(desc_ctl_in), .desc_addr_in(desc_addr_in),
    .st_en(st_en), .st_act(st_act), .irq_buf_end(irq_buf_end),
    .irq_desc_loaded(irq_desc_loaded)
  );

  always @(posedge clk) begin
    if (out_valid && out_rdy) pops++;
    if (irq_buf_end) eobs++;
  end

  function automatic logic [31:0] mk(input logic [15:0] len, input logic [7:0] bits);
    return {len, 8'h00, bits};
  endfunction

  function automatic logic [31:0] end_addr(input logic [31:0] a, input int n);
    return a + 32'(n * 4);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic ack(input logic [31:0] c, input logic [31:0] a);
    desc_ack = 1'b1; desc_ctl_in = c; desc_addr_in = a;
    @(negedge clk);
    desc_ack = 1'b0;
  endtask

  task automatic wait_idle(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (!st_en) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p0, e0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 st_en", st_en, 0);
    chk("R1 st_act", st_act, 0);
    chk("R1 desc_req", desc_req, 0);
    chk("R1 ctl_word", ctl_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 irqs", {irq_buf_end, irq_desc_loaded}, 0);

    // R2: disabled channel ignores requests
    wr(mk(16'd7, 8'h00));
    xfer_req = 1'b1; out_rdy = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 no beat", out_valid, 0);
    chk("R2 length kept", ctl_word[31:16], 7);

    // R3/R4/R11: run and stop
    p0 = pops; e0 = eobs;
    out_rdy = 1'b1;
    wr(mk(16'd6, 8'h21));
    chk("R3 st_en set", st_en, 1);
    wait_idle(100);
    @(negedge clk);
    chk("R3 beats delivered", pops - p0, 6);
    chk("R3 address advance", buf_addr, end_addr(0, 6));
    chk("R4 buffer end pulse", eobs - e0, 1);
    chk("R4 length zero", ctl_word[31:16], 0);
    chk("R11 no fetch", desc_req, 0);

    // R3/R5/R10: halt with full FIFO
    p0 = pops;
    out_rdy = 1'b0;
    wr(mk(16'd20, 8'h01));
    repeat (8) @(negedge clk);
    chk("R3 FIFO cap", ctl_word[31:16], 20 - DEPTH);
    chk("R10 active", st_act, 1);
    wr(mk(16'd16, 8'h00));
    repeat (5) @(negedge clk);
    chk("R5 running while draining", st_en, 1);
    chk("R5 no fill", ctl_word[31:16], 16);
    out_rdy = 1'b1;
    wait_idle(50);
    chk("R5 drained", pops - p0, DEPTH);
    chk("R10 inactive", st_act, 0);

    // R8/R9: skip during drain
    p0 = pops;
    out_rdy = 1'b0;
    wr(mk(16'd20, 8'h01));
    repeat (8) @(negedge clk);
    xfer_req = 1'b0;
    wr(mk(16'd16, 8'h02));
    repeat (3) @(negedge clk);
    chk("R8 no early fetch", desc_req, 0);
    out_rdy = 1'b1;
    wait_idle(50);
    chk("R8 fetch after drain", desc_req, 1);
    chk("R8 length untouched", ctl_word[31:16], 16);
    chk("R8 only FIFO beats", pops - p0, DEPTH);
    repeat (2) @(negedge clk);
    chk("R9 req held", desc_req, 1);
    ack(mk(16'd3, 8'h41), 32'h1000);
    chk("R9 word loaded", ctl_word, mk(16'd3, 8'h41));
    chk("R9 addr loaded", buf_addr, 32'h1000);
    chk("R9 st_en from word", st_en, 1);
    chk("R9 loaded pulse", irq_desc_loaded, 1);
    chk("R9 req dropped", desc_req, 0);
    @(negedge clk);
    chk("R9 pulse one cycle", irq_desc_loaded, 0);
    p0 = pops;
    xfer_req = 1'b1;
    wait_idle(50);
    @(negedge clk);
    chk("R3 second buffer", pops - p0, 3);
    chk("R3 second addr", buf_addr, 32'h100C);
    chk("R11 stop no fetch", desc_req, 0);

    // R7/R10: fetch now
    xfer_req = 1'b0;
    wr(mk(16'd0, 8'h02));
    repeat (4) @(negedge clk);
    chk("R7 waits for request", desc_req, 0);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    chk("R7 fetch on request", desc_req, 1);
    chk("R7 no beat", out_valid, 0);
    ack(mk(16'd5, 8'h00), 32'h2000);
    chk("R10 idle after load", st_en, 0);
    chk("R9 no pulse when gated", irq_desc_loaded, 0);
    xfer_req = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 no request", desc_req, 0);
    chk("R10 no movement", ctl_word[31:16], 5);
    p0 = pops;
    wr(mk(16'd5, 8'h01));
    wait_idle(50);
    @(negedge clk);
    chk("R10 resume by write", pops - p0, 5);

    // R6: run and link chain
    p0 = pops;
    wr(mk(16'd4, 8'h03));
    wait_idle(50);
    chk("R6 link fetch", desc_req, 1);
    ack(mk(16'd3, 8'h03), 32'h3000);
    wait_idle(50);
    chk("R6 second link", desc_req, 1);
    ack(mk(16'd2, 8'h01), 32'h4000);
    wait_idle(50);
    @(negedge clk);
    chk("R6 chain beats", pops - p0, 9);
    chk("R6 chain addr", buf_addr, 32'h4008);
    chk("R11 chain end", desc_req, 0);

    // random buffers
    for (int r = 0; r < 25; r++) begin
      int n;
      logic [31:0] a;
      n = $urandom_range(1, 24);
      a = $urandom & 32'hFFFF_FFF0;
      xfer_req = 1'b1;
      wr(mk(16'd0, 8'h02));
      for (int i = 0; i < 20 && !desc_req; i++) @(negedge clk);
      p0 = pops; e0 = eobs;
      ack(mk(16'(n), 8'h21), a);
      for (int i = 0; i < 3000 && st_en; i++) begin
        xfer_req = ($urandom_range(0, 3) != 0);
        out_rdy  = ($urandom_range(0, 2) != 0);
        @(negedge clk);
      end
      out_rdy = 1'b1;
      @(negedge clk);
      chk("R3 random beats", pops - p0, n);
      chk("R3 random addr", buf_addr, end_addr(a, n));
      chk("R4 random end pulse", eobs - e0, 1);
      chk("R10 random inactive", st_act, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule